// File: doc/BRIEF.md
# Multiplexed Display Grid Timing Controller

This block drives a vacuum fluorescent display through time multiplexing. It has 27 segment lines and up to three grid lines, so it can address up to 81 display points. It keeps a 27-bit segment pattern for each grid. It visits the grids one slot at a time, and a slot lasts 4096 enabled clock cycles. During each slot it places the pattern of the current grid on the segment bus and pulls that grid's enable line low.

A single pin selects the duty:
- **Thirding (1/3 duty):** all three grids are used.
- **Halving (1/2 duty):** only the first two grids are used.

Brightness comes from a 10-bit dimming value. The grid and its segments are lit only for the first `dim × 4` enabled cycles of a slot and stay blank for the rest. All pattern and dimming writes go into shadow registers. They are copied into the working copies only at a slot boundary, so the display never changes in the middle of a slot.

The timing is built around a two-state lamp machine:
- **States:**
  - `ST_BLANK`: grids off, segments zero.
  - `ST_LIT`: one grid on, its pattern shown.
- **Transitions:**
  - `LIGHT_UP`: `ST_BLANK` to `ST_LIT` at a slot boundary when the incoming dimming value is nonzero.
  - `STAY_DARK`: `ST_BLANK` to `ST_BLANK` at a slot boundary when the incoming dimming value is zero.
  - `CUT_OFF`: `ST_LIT` to `ST_BLANK` when the on-time has elapsed.

An input `tick` acts as the clock enable for all slot timing.

Top module: `vfd_grid_mux`

## Requirements
- R1: While `rst_n` is low, and afterwards, all of the following hold until the first slot boundary:
  - every grid enable (`grid_n`) is 1;
  - `seg_out` is 0;
  - `dim_pulse` is 0;
  - all pattern and dimming registers are cleared, so the first slot after reset is dark.
- R2: A slot lasts exactly 4096 cycles in which `tick` is 1. The first slot after reset belongs to grid 0. With `duplex_sel`=0 the grids follow the order 0, 1, 2, 0, and so on.
- R3: With `duplex_sel`=1 the order is 0, 1, 0, and so on. Grid 2 is never enabled. A slot that follows a grid-2 slot goes to grid 0. The mode is sampled at each slot boundary.
- R4: `grid_n` is active low, and bit k belongs to grid k. At most one bit is 0 at any time.
- R5: While grid k is enabled, `seg_out` equals the pattern last written with `seg_wr_sel`=k (only values 0 to 2 are used). While no grid is enabled, `seg_out` is 0.
- R6: In a slot with dimming value d > 0, the grid is enabled for exactly the first 4·d ticks of the slot. `dim_pulse` is 1 exactly while a grid is enabled.
- R7: A dimming value of 0 keeps all grids disabled for the whole slot.
- R8: A dimming value of 1023 gives 4092 enabled ticks. Between the enabled windows of two slots there is always at least one cycle with no grid enabled.
- R9: Pattern and dimming writes take effect only at the next slot boundary. A write made during an enabled window does not change the pattern being shown.
- R10: While `tick` is 0, the slot position, the grid and all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable for slot timing |
| duplex_sel | input | 1 | 1 selects 1/2 duty (grids 0 and 1); 0 selects 1/3 duty |
| seg_wr_en | input | 1 | Write strobe for a segment pattern |
| seg_wr_sel | input | 2 | Grid whose shadow pattern is written |
| seg_wr_data | input | 27 | Segment pattern, bit i drives segment i |
| dim_wr_en | input | 1 | Write strobe for the dimming value |
| dim_wr_data | input | 10 | Dimming value |
| seg_out | output | 27 | Segment bus |
| grid_n | output | 3 | Grid enables, active low |
| dim_pulse | output | 1 | High during the lit window |

## Verification
Each kind of internal fault shows up at the ports, and the list below says how soon:
- **Wrong slot counter:** the length of the lit window changes, or the slot boundaries shift. This is visible at the end of the first affected window.
- **Wrong grid index:** the wrong `grid_n` bit goes low, or a grid is skipped in the sequence. This is visible at the next boundary.
- **Shadow copy committed early:** a pattern or brightness change appears in the middle of a window. This is visible within a cycle of the write.
- **Stale lamp state:** a lit grid that changes to another grid with no blank cycle between them, or segment bits left on while no grid is enabled. This is visible on the cycle it happens.

The scoreboard compares the grid, the pattern and the ticked length of every lit window against a model built only from the requirements.

// File: rtl/vfd_grid_mux_pkg.sv
package vfd_grid_mux_pkg;
    // Lamp state of the current slot
    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_LIT   = 1'b1
    } lamp_state_e;
endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
    parameter int SLOT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot_pos,
    output logic              slot_last
);
    localparam logic [SLOT_W-1:0] POS_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_pos <= '0;
        end else if (tick) begin
            slot_pos <= slot_pos + SLOT_W'(1);
        end
    end

    assign slot_last = (slot_pos == POS_MAX);
endmodule

// File: rtl/vfd_latch_bank.sv
module vfd_latch_bank #(
    parameter int SEG_W  = 27,
    parameter int GRID_N = 3,
    parameter int DIM_W  = 10,
    parameter int SEL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [SEL_W-1:0] seg_wr_sel,
    input  logic [SEG_W-1:0] seg_wr_data,
    input  logic             dim_wr_en,
    input  logic [DIM_W-1:0] dim_wr_data,
    input  logic             commit,
    output logic [SEG_W-1:0] pat_act [GRID_N],
    output logic [DIM_W-1:0] dim_next,
    output logic [DIM_W-1:0] dim_act
);
    logic [SEG_W-1:0] pat_shd [GRID_N];
    logic [DIM_W-1:0] dim_shd;

    // Shadow copies accept writes on any cycle; working copies move only on commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < GRID_N; g++) begin
                pat_shd[g] <= '0;
                pat_act[g] <= '0;
            end
            dim_shd <= '0;
            dim_act <= '0;
        end else begin
            for (int g = 0; g < GRID_N; g++) begin
                if (seg_wr_en && (seg_wr_sel == SEL_W'(g))) begin
                    pat_shd[g] <= seg_wr_data;
                end
                if (commit) begin
                    pat_act[g] <= pat_shd[g];
                end
            end
            if (dim_wr_en) begin
                dim_shd <= dim_wr_data;
            end
            if (commit) begin
                dim_act <= dim_shd;
            end
        end
    end

    assign dim_next = dim_shd;
endmodule

// File: rtl/vfd_grid_seq.sv
module vfd_grid_seq
    import vfd_grid_mux_pkg::*;
#(
    parameter int SEG_W  = 27,
    parameter int GRID_N = 3,
    parameter int FEW_N  = 2,
    parameter int DIM_W  = 10,
    parameter int SLOT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              duplex_sel,
    input  logic [SLOT_W-1:0] slot_pos,
    input  logic              slot_last,
    input  logic [DIM_W-1:0]  dim_next,
    input  logic [DIM_W-1:0]  dim_act,
    input  logic [SEG_W-1:0]  pat_act [GRID_N],
    output logic [SEG_W-1:0]  seg_out,
    output logic [GRID_N-1:0] grid_n,
    output logic              dim_pulse
);
    localparam int GIDX_W = (GRID_N > 1) ? $clog2(GRID_N) : 1;
    localparam int SHIFT  = SLOT_W - DIM_W;
    localparam logic [GIDX_W-1:0] LAST_FULL = GIDX_W'(GRID_N - 1);
    localparam logic [GIDX_W-1:0] LAST_FEW  = GIDX_W'(FEW_N - 1);

    lamp_state_e       state_q, state_d;
    logic [GIDX_W-1:0] grid_q, grid_d;
    logic [GIDX_W-1:0] last_idx;
    logic [SLOT_W-1:0] on_len;
    logic              boundary;

    assign boundary = tick && slot_last;
    assign last_idx = duplex_sel ? LAST_FEW : LAST_FULL;
    assign on_len   = SLOT_W'(dim_act) << SHIFT;

    // Next state and next grid
    always_comb begin
        state_d = state_q;
        grid_d  = grid_q;
        if (boundary) begin
            grid_d = (grid_q >= last_idx) ? '0 : grid_q + GIDX_W'(1);
            if (dim_next != '0) begin
                state_d = ST_LIT;      // LIGHT_UP
            end else begin
                state_d = ST_BLANK;    // STAY_DARK
            end
        end else if (tick) begin
            unique case (state_q)
                ST_LIT: begin
                    if ((slot_pos + SLOT_W'(1)) == on_len) begin
                        state_d = ST_BLANK;  // CUT_OFF
                    end
                end
                ST_BLANK: begin
                    state_d = ST_BLANK;
                end
                default: state_d = ST_BLANK;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
            grid_q  <= '0;
        end else begin
            state_q <= state_d;
            grid_q  <= grid_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_LIT: begin
                seg_out   = pat_act[grid_q];
                dim_pulse = 1'b1;
            end
            default: begin
                seg_out   = '0;
                dim_pulse = 1'b0;
            end
        endcase
    end

    for (genvar k = 0; k < GRID_N; k++) begin : g_grid_drv
        assign grid_n[k] = !((state_q == ST_LIT) && (grid_q == GIDX_W'(k)));
    end
endmodule

// File: rtl/vfd_grid_mux.sv
module vfd_grid_mux #(
    parameter int SEG_W  = 27,
    parameter int GRID_N = 3,
    parameter int FEW_N  = 2,
    parameter int DIM_W  = 10,
    parameter int SLOT_W = 12,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              duplex_sel,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              dim_wr_en,
    input  logic [DIM_W-1:0]  dim_wr_data,
    output logic [SEG_W-1:0]  seg_out,
    output logic [GRID_N-1:0] grid_n,
    output logic              dim_pulse
);
    logic [SLOT_W-1:0] slot_pos;
    logic              slot_last;
    logic [SEG_W-1:0]  pat_act [GRID_N];
    logic [DIM_W-1:0]  dim_next;
    logic [DIM_W-1:0]  dim_act;

    vfd_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .slot_pos  (slot_pos),
        .slot_last (slot_last)
    );

    vfd_latch_bank #(
        .SEG_W(SEG_W), .GRID_N(GRID_N), .DIM_W(DIM_W), .SEL_W(SEL_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .seg_wr_en   (seg_wr_en),
        .seg_wr_sel  (seg_wr_sel),
        .seg_wr_data (seg_wr_data),
        .dim_wr_en   (dim_wr_en),
        .dim_wr_data (dim_wr_data),
        .commit      (tick && slot_last),
        .pat_act     (pat_act),
        .dim_next    (dim_next),
        .dim_act     (dim_act)
    );

    vfd_grid_seq #(
        .SEG_W(SEG_W), .GRID_N(GRID_N), .FEW_N(FEW_N),
        .DIM_W(DIM_W), .SLOT_W(SLOT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .duplex_sel (duplex_sel),
        .slot_pos   (slot_pos),
        .slot_last  (slot_last),
        .dim_next   (dim_next),
        .dim_act    (dim_act),
        .pat_act    (pat_act),
        .seg_out    (seg_out),
        .grid_n     (grid_n),
        .dim_pulse  (dim_pulse)
    );
endmodule

// File: rtl/vfd_grid_mux_chk.sv
module vfd_grid_mux_chk #(
    parameter int SEG_W  = 27,
    parameter int GRID_N = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              duplex_sel,
    input logic [SEG_W-1:0]  seg_out,
    input logic [GRID_N-1:0] grid_n,
    input logic              dim_pulse
);
    localparam logic [GRID_N-1:0] ALL_OFF = '1;

    // R4: never more than one grid enabled
    p_one_grid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~grid_n) <= 1);

    // R5: segment bus is zero while no grid is enabled
    p_seg_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_n == ALL_OFF) |-> (seg_out == '0));

    // R6: dimming pulse tracks the lit window
    p_pulse_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dim_pulse == (grid_n != ALL_OFF));

    // R8: two consecutive lit cycles belong to the same grid
    p_gap_between_grids_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((grid_n != ALL_OFF) && ($past(grid_n) != ALL_OFF)) |-> (grid_n == $past(grid_n)));

    // R3: grid 2 only lights up when thirding was selected at the boundary
    p_no_third_grid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grid_n[GRID_N-1]) |-> !$past(duplex_sel));

    // R10: outputs hold while the clock enable is low
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(grid_n) && $stable(seg_out)));
endmodule

bind vfd_grid_mux vfd_grid_mux_chk #(.SEG_W(SEG_W), .GRID_N(GRID_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .duplex_sel (duplex_sel),
    .seg_out    (seg_out),
    .grid_n     (grid_n),
    .dim_pulse  (dim_pulse)
);

// File: tb/vfd_grid_mux_tb.sv
module vfd_grid_mux_tb;
    localparam int SLOT = 4096;

    typedef struct {
        int          grid;
        logic [26:0] pat;
        int          len;
        string       tag;
    } burst_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        duplex_sel = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [26:0] seg_wr_data = '0;
    logic        dim_wr_en = 1'b0;
    logic [9:0]  dim_wr_data = '0;
    logic [26:0] seg_out;
    logic [2:0]  grid_n;
    logic        dim_pulse;

    int checks = 0;
    int failures = 0;
    int tb_ticks = 0;
    int bursts = 0;
    int blank_err = 0;
    int exp_grid = 0;
    int exp_bursts = 0;
    logic [26:0] lat_model [3];
    burst_t exp_q [$];
    bit stall_on = 1'b0;

    vfd_grid_mux u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .duplex_sel(duplex_sel),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .dim_wr_en(dim_wr_en), .dim_wr_data(dim_wr_data),
        .seg_out(seg_out), .grid_n(grid_n), .dim_pulse(dim_pulse)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) tb_ticks <= 0;
        else if (tick) tb_ticks <= tb_ticks + 1;
    end

    // Clock-enable pattern: one idle cycle in three while stalling
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #1;
            if (stall_on) begin
                ph = (ph + 1) % 3;
                tick = (ph != 0);
            end else begin
                tick = 1'b1;
            end
        end
    end

    // Monitor: pops an expected window at each lit window start
    burst_t cur;
    bit     in_burst = 1'b0;
    int     cur_len = 0;
    bit     bad_grid = 1'b0;
    bit     bad_pat = 1'b0;
    bit     bad_pulse = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            in_burst = 1'b0;
        end else begin
            if (grid_n != 3'b111) begin
                if (!in_burst) begin
                    bursts++;
                    in_burst = 1'b1;
                    cur_len = 0;
                    bad_grid = 1'b0;
                    bad_pat = 1'b0;
                    bad_pulse = 1'b0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2", "unexpected lit window grid_n", grid_n, 3'b111);
                        cur.grid = 0; cur.pat = '0; cur.len = 0; cur.tag = "R2";
                    end else begin
                        cur = exp_q.pop_front();
                    end
                end
                if (grid_n != ~(3'b001 << cur.grid)) bad_grid = 1'b1;
                if (seg_out != cur.pat) bad_pat = 1'b1;
                if (!dim_pulse) bad_pulse = 1'b1;
                if (tick) cur_len++;
            end else begin
                if (seg_out != '0 || dim_pulse) blank_err++;
                if (in_burst) begin
                    in_burst = 1'b0;
                    chk(!bad_grid, cur.tag, "grid of window", cur.grid, cur.grid);
                    chk(!bad_pat, "R5", "segment pattern held in window (R9)", seg_out, cur.pat);
                    chk(!bad_pulse, "R6", "dim_pulse during window", 0, 1);
                    chk(cur_len == cur.len, cur.tag, "ticked window length (R6)", cur_len, cur.len);
                end
            end
        end
    end

    task automatic wait_pos(input int slot, input int pos);
        while (tb_ticks < slot * SLOT + pos) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_seg(input int sel, input logic [26:0] d);
        @(posedge clk); #1;
        seg_wr_en = 1'b1; seg_wr_sel = 2'(sel); seg_wr_data = d;
        @(posedge clk); #1;
        seg_wr_en = 1'b0;
        lat_model[sel] = d;
    endtask

    task automatic write_dim(input logic [9:0] d);
        @(posedge clk); #1;
        dim_wr_en = 1'b1; dim_wr_data = d;
        @(posedge clk); #1;
        dim_wr_en = 1'b0;
    endtask

    // Driver: sets mode and dimming for the next slot, pushes the expected window
    task automatic advance(input bit dup, input int dim, input string tag);
        int last;
        duplex_sel = dup;
        write_dim(10'(dim));
        last = dup ? 1 : 2;
        exp_grid = (exp_grid >= last) ? 0 : exp_grid + 1;
        if (dim != 0) begin
            burst_t b;
            b.grid = exp_grid; b.pat = lat_model[exp_grid]; b.len = dim * 4; b.tag = tag;
            exp_q.push_back(b);
            exp_bursts++;
        end
    endtask

    initial begin
        int snap;
        for (int g = 0; g < 3; g++) lat_model[g] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(grid_n == 3'b111, "R1", "grid_n in reset", grid_n, 3'b111);
        chk(seg_out == '0, "R1", "seg_out in reset", seg_out, 0);
        chk(dim_pulse == 1'b0, "R1", "dim_pulse in reset", dim_pulse, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Slot 0 is dark; load patterns for later slots
        wait_pos(0, 100);
        write_seg(0, 27'h1234567);
        write_seg(1, 27'h7654321);
        write_seg(2, 27'h5A5A5A5);
        chk(grid_n == 3'b111, "R1", "first slot after reset dark", grid_n, 3'b111);
        advance(1'b0, 5, "R2");               // slot 1: grid 1
        wait_pos(1, 100); advance(1'b0, 5, "R2");   // slot 2: grid 2
        wait_pos(2, 100); advance(1'b0, 5, "R2");   // slot 3: grid 0
        wait_pos(3, 100); advance(1'b0, 1023, "R8"); // slot 4: grid 1, full on
        wait_pos(4, 100);
        // R9: written mid-window, shown only from slot 5 on
        write_seg(1, 27'h0F0F0F0);
        write_seg(2, 27'h3C3C3C3);
        advance(1'b0, 1023, "R8");            // slot 5: grid 2
        wait_pos(5, 100); advance(1'b1, 1, "R3");   // slot 6: grid 0 after grid 2
        wait_pos(6, 100); advance(1'b1, 1, "R3");   // slot 7: grid 1
        wait_pos(7, 100); advance(1'b1, 1, "R3");   // slot 8: grid 0
        wait_pos(8, 100);
        advance(1'b1, 0, "R7");               // slot 9: grid 1, dark
        snap = bursts;
        wait_pos(9, 4000);
        chk(bursts == snap, "R7", "windows during zero-dim slot", bursts - snap, 0);
        chk(grid_n == 3'b111, "R7", "grid_n in zero-dim slot", grid_n, 3'b111);
        stall_on = 1'b1;
        advance(1'b0, 2, "R10");              // slot 10: grid 2, stalled
        wait_pos(10, 100);
        write_seg(0, 27'h7FFFFFF);
        advance(1'b0, 3, "R10");              // slot 11: grid 0
        wait_pos(11, 100);
        stall_on = 1'b0;
        advance(1'b0, 3, "R2");               // slot 12: grid 1
        wait_pos(12, 200);
        chk(exp_q.size() == 0, "R2", "expected windows left over", exp_q.size(), 0);
        chk(bursts == exp_bursts, "R2", "window count", bursts, exp_bursts);
        chk(blank_err == 0, "R5", "seg/pulse nonzero while blank", blank_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired R2 actual=%0d expected=%0d", tb_ticks, 12 * SLOT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule